// File: doc/BRIEF.md
# HDLC Serial Receive Deframer

This block takes a bit-serial HDLC stream, one bit per cycle in which the bit-valid input is high, and turns it into octets on an 8-bit parallel output with a one-cycle byte strobe. It finds opening and closing flags and abort sequences, and removes the zeros that the transmitter stuffed into the data. It checks the frame check sequence with a 16-bit or a 32-bit CRC, chosen by a select input.

Every flag octet is forwarded on the byte output with its own strobe, so a downstream buffer sees the gap between packets as well as the packets. Two level outputs report each message boundary. IDLE high with VALFCS high means a good FCS. IDLE high with VALFCS low means a bad FCS. IDLE low with VALFCS high means an abort. Both are low while a message is being received.

An enable input gates the whole receiver. While the enable is low, line bits are ignored. Once it is raised again, the receiver hunts for a flag before it accepts data.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While en_i is low, no byte strobe is issued and idle_o/valfcs_o keep their values; after re-enable, data is accepted only after a flag.
- R2: The first destuffed bit of an octet lands in data_o[0] and the eighth in data_o[7].
- R3: Each received flag (bit sequence 0,1,1,1,1,1,1,0) gives one strobe with data_o = 0x7E and idle_o high.
- R4: A flag that closes an octet-aligned message whose CRC residue matches gives idle_o = 1 and valfcs_o = 1.
- R5: A flag that closes a message whose residue does not match gives idle_o = 1 and valfcs_o = 0.
- R6: Seven consecutive ones inside a message give idle_o = 0 and valfcs_o = 1 with no strobe; partial octets are dropped, and the receiver hunts for the next flag.
- R7: The strobe of a message's first data octet drives idle_o and valfcs_o low, and both stay low until that message ends.
- R8: With exactly one flag between two packets, exactly one strobe with idle_o high is issued between their data octets.
- R9: With crc32_sel_i low, the CRC is x^16+x^12+x^5+1 and the residue must be 0xF0B8. With it high, the CRC is the standard 32-bit polynomial and the residue must be 0xDEBB20E3. In both cases the register is preset to all ones and fed LSB first, and the FCS is the complemented CRC, sent low byte first.
- R10: A zero that follows five consecutive ones is deleted, so octets with long runs of ones are recovered intact.
- R11: data_o changes only on a cycle in which strobe_o is high.
- R12: A message whose length at its closing flag is not a whole number of octets is reported as a bad FCS.
- R13: Out of reset, strobe_o = 0, data_o = 0, idle_o = 1 and valfcs_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| crc32_sel_i | input | 1 | 1 selects the 32-bit CRC, 0 the 16-bit CRC |
| bit_vld_i | input | 1 | bit_i carries a line bit this cycle |
| bit_i | input | 1 | Serial line bit |
| data_o | output | 8 | Received octet or flag |
| strobe_o | output | 1 | One-cycle pulse per octet or flag |
| idle_o | output | 1 | Message boundary indication |
| valfcs_o | output | 1 | FCS and abort indication |

## Verification
The main path is tried with three kinds of frame:
- A short frame of asymmetric and ones-heavy octets (0x01, 0x80, 0x7E, 0xFF). It separates bit-order faults from stuffing faults.
- Frames holding all 256 octet values under both CRCs. These tell a correct residue from a wrong polynomial or a wrong preset.
- Corrupted and wrongly selected FCS fields. These separate good from bad verdicts.

Boundary patterns cover the rest:
- back-to-back flags and a single flag between packets;
- an abort after two octets, with a third octet still in flight;
- a frame ending three bits past an octet;
- a complete frame sent while the receiver is disabled.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int          OCTET_W     = 8;
  localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
  localparam logic [15:0] CRC16_POLY  = 16'h8408;
  localparam logic [15:0] CRC16_MAGIC = 16'hF0B8;
  localparam logic [31:0] CRC32_POLY  = 32'hEDB88320;
  localparam logic [31:0] CRC32_MAGIC = 32'hDEBB20E3;

  typedef struct packed {
    logic dbit;   // bit is payload
    logic run6;   // sixth one seen: held bits were flag/abort prefix
    logic flag;
    logic abort;
  } line_ev_t;
endpackage

// File: rtl/hdlc_destuff.sv
module hdlc_destuff
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     vld_i,
  input  logic     bit_i,
  output line_ev_t ev_o
);
  localparam int CNT_W = $clog2(STUFF_RUN + 3);
  localparam logic [CNT_W-1:0] RUN_C = CNT_W'(STUFF_RUN);
  localparam logic [CNT_W-1:0] FLG_C = CNT_W'(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(STUFF_RUN + 2);

  logic [CNT_W-1:0] ones_q, ones_d;

  always_comb begin
    ev_o   = '0;
    ones_d = ones_q;
    if (!en_i) begin
      ones_d = '0;
    end else if (vld_i) begin
      ev_o.dbit = ones_q < RUN_C;
      if (bit_i) begin
        if (ones_q != SAT_C) ones_d = ones_q + 1'b1;
        ev_o.run6  = ones_q == RUN_C;
        ev_o.abort = ones_q == FLG_C;
      end else begin
        ones_d    = '0;
        ev_o.flag = ones_q == FLG_C;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else         ones_q <= ones_d;
  end
endmodule

// File: rtl/hdlc_octet_asm.sv
module hdlc_octet_asm #(
  parameter int OCTET_W = 8,
  parameter int HOLD    = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               drop_hold_i,
  input  logic               push_i,
  input  logic               bit_i,
  output logic               commit_o,
  output logic               commit_bit_o,
  output logic               done_o,
  output logic [OCTET_W-1:0] octet_o,
  output logic               partial_o
);
  localparam int HC_W = $clog2(HOLD + 1);
  localparam int AC_W = $clog2(OCTET_W);
  localparam logic [HC_W-1:0] HOLD_C = HC_W'(HOLD);
  localparam logic [AC_W-1:0] LAST_C = AC_W'(OCTET_W - 1);

  logic [HOLD-1:0]    hold_q;
  logic [HC_W-1:0]    hold_cnt_q;
  logic [OCTET_W-1:0] asm_q;
  logic [AC_W-1:0]    asm_cnt_q;

  // a bit is trusted once HOLD newer payload bits followed it
  assign commit_o     = push_i && (hold_cnt_q == HOLD_C);
  assign commit_bit_o = hold_q[0];
  assign done_o       = commit_o && (asm_cnt_q == LAST_C);
  assign octet_o      = {hold_q[0], asm_q[OCTET_W-1:1]};
  assign partial_o    = asm_cnt_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_cnt_q <= '0;
      asm_q      <= '0;
      asm_cnt_q  <= '0;
    end else if (clr_i) begin
      hold_cnt_q <= '0;
      asm_cnt_q  <= '0;
    end else begin
      if (drop_hold_i) begin
        hold_cnt_q <= '0;
      end else if (push_i) begin
        hold_q <= {bit_i, hold_q[HOLD-1:1]};
        if (hold_cnt_q != HOLD_C) hold_cnt_q <= hold_cnt_q + 1'b1;
      end
      if (commit_o) begin
        asm_q     <= {hold_q[0], asm_q[OCTET_W-1:1]};
        asm_cnt_q <= done_o ? '0 : asm_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_crc_chk.sv
module hdlc_crc_chk #(
  parameter int           W     = 16,
  parameter logic [W-1:0] POLY  = '0,
  parameter logic [W-1:0] MAGIC = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic upd_i,
  input  logic bit_i,
  output logic ok_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb   = crc_q[0] ^ bit_i;
  assign ok_o = crc_q == MAGIC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (upd_i)  crc_q <= (crc_q >> 1) ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               crc32_sel_i,
  input  logic               bit_vld_i,
  input  logic               bit_i,
  output logic [OCTET_W-1:0] data_o,
  output logic               strobe_o,
  output logic               idle_o,
  output logic               valfcs_o
);
  localparam int HOLD = STUFF_RUN + 1;

  line_ev_t           ev;
  logic               hunting_q, in_msg_q;
  logic               push, clr;
  logic               commit, commit_bit, done, partial;
  logic [OCTET_W-1:0] octet;
  logic               ok16, ok32, fcs_ok;
  logic [OCTET_W-1:0] data_q;
  logic               strobe_q, idle_q, valfcs_q;

  hdlc_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
    .clk_i, .rst_ni, .en_i,
    .vld_i(bit_vld_i), .bit_i,
    .ev_o (ev)
  );

  assign push = ev.dbit && !hunting_q;
  assign clr  = ev.flag || ev.abort || !en_i;

  hdlc_octet_asm #(.OCTET_W(OCTET_W), .HOLD(HOLD)) u_asm (
    .clk_i, .rst_ni,
    .clr_i       (clr),
    .drop_hold_i (ev.run6),
    .push_i      (push),
    .bit_i       (bit_i),
    .commit_o    (commit),
    .commit_bit_o(commit_bit),
    .done_o      (done),
    .octet_o     (octet),
    .partial_o   (partial)
  );

  hdlc_crc_chk #(.W(16), .POLY(CRC16_POLY), .MAGIC(CRC16_MAGIC)) u_crc16 (
    .clk_i, .rst_ni, .init_i(clr), .upd_i(commit), .bit_i(commit_bit), .ok_o(ok16)
  );

  hdlc_crc_chk #(.W(32), .POLY(CRC32_POLY), .MAGIC(CRC32_MAGIC)) u_crc32 (
    .clk_i, .rst_ni, .init_i(clr), .upd_i(commit), .bit_i(commit_bit), .ok_o(ok32)
  );

  assign fcs_ok = (crc32_sel_i ? ok32 : ok16) && !partial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hunting_q <= 1'b1;
      in_msg_q  <= 1'b0;
      data_q    <= '0;
      strobe_q  <= 1'b0;
      idle_q    <= 1'b1;
      valfcs_q  <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (!en_i) begin
        hunting_q <= 1'b1;
        in_msg_q  <= 1'b0;
      end else if (ev.flag) begin
        hunting_q <= 1'b0;
        in_msg_q  <= 1'b0;
        strobe_q  <= 1'b1;
        data_q    <= FLAG_OCTET;
        idle_q    <= 1'b1;
        // a flag that closes nothing clears a pending abort code
        valfcs_q  <= in_msg_q ? fcs_ok : (valfcs_q && idle_q);
      end else if (ev.abort) begin
        hunting_q <= 1'b1;
        in_msg_q  <= 1'b0;
        if (in_msg_q) begin
          idle_q   <= 1'b0;
          valfcs_q <= 1'b1;
        end
      end else if (done) begin
        strobe_q <= 1'b1;
        data_q   <= octet;
        in_msg_q <= 1'b1;
        if (!in_msg_q) begin
          idle_q   <= 1'b0;
          valfcs_q <= 1'b0;
        end
      end
    end
  end

  assign data_o   = data_q;
  assign strobe_o = strobe_q;
  assign idle_o   = idle_q;
  assign valfcs_o = valfcs_q;
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [7:0] data_o,
  input logic       strobe_o,
  input logic       idle_o,
  input logic       valfcs_o
);
  a_r1_no_strobe_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !strobe_o);

  a_r3_idle_strobe_is_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && idle_o) |-> (data_o == 8'h7E));

  a_r6_abort_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(valfcs_o) && !idle_o) |-> !strobe_o);

  a_r7_start_on_octet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_o) |-> (strobe_o && !valfcs_o));

  a_r7_data_clears_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !idle_o) |-> !valfcs_o);

  a_r11_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(data_o));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk_i, .rst_ni, .en_i, .data_o, .strobe_o, .idle_o, .valfcs_o
);

// File: tb/hdlc_rx_deframer_bench.sv
module hdlc_rx_deframer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, sel32 = 1'b0, vld = 1'b0, bit_in = 1'b0;
  logic [7:0] data;
  logic       strobe, idle, valfcs;

  always #4 clk = ~clk;

  hdlc_rx_deframer u_hdlc_rx_deframer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .crc32_sel_i(sel32),
    .bit_vld_i(vld), .bit_i(bit_in),
    .data_o(data), .strobe_o(strobe), .idle_o(idle), .valfcs_o(valfcs)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] cap_d [0:2047];
  logic       cap_i [0:2047];
  logic       cap_v [0:2047];
  int         cap_n = 0;
  logic [7:0] exp_d [0:2047];
  logic       exp_i [0:2047];
  logic       exp_v [0:2047];
  int         exp_n = 0, cmp_base = 0, cap_off = 0;
  int         stable_viol = 0;
  logic [7:0] last_data = 8'h00;

  always @(negedge clk) begin
    if (strobe) begin
      if (cap_n < 2048) begin
        cap_d[cap_n] = data; cap_i[cap_n] = idle; cap_v[cap_n] = valfcs;
      end
      cap_n++;
    end else if (rst_n && data !== last_data) begin
      stable_viol++;
    end
    last_data = data;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // receiver status model
  bit m_idle = 1, m_val = 0, m_inmsg = 0, m_good = 0, m_on = 0;
  int tx_ones = 0;
  logic [7:0] frm [0:299];

  task automatic exp_push(input logic [7:0] d, input logic i, input logic v);
    exp_d[exp_n] = d; exp_i[exp_n] = i; exp_v[exp_n] = v; exp_n++;
  endtask

  task automatic raw_bit(input logic b);
    @(negedge clk); bit_in = b; vld = 1'b1;
    @(negedge clk); vld = 1'b0; bit_in = 1'b0;
  endtask

  task automatic data_bit(input logic b);
    raw_bit(b);
    tx_ones = b ? tx_ones + 1 : 0;
    if (tx_ones == 5) begin raw_bit(1'b0); tx_ones = 0; end
  endtask

  task automatic data_byte(input logic [7:0] d);
    for (int k = 0; k < 8; k++) data_bit(d[k]);
    if (m_on) begin
      if (!m_inmsg) begin m_idle = 0; m_val = 0; m_inmsg = 1; end
      exp_push(d, 1'b0, 1'b0);
    end
  endtask

  task automatic send_flag();
    for (int k = 0; k < 8; k++) raw_bit(k != 0 && k != 7);
    tx_ones = 0;
    if (m_on) begin
      if (m_inmsg) m_val = m_good; else m_val = m_val & m_idle;
      m_idle = 1; m_inmsg = 0;
      exp_push(8'h7E, 1'b1, m_val);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int n, input bit c32);
    logic [31:0] c, p;
    c = c32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    p = c32 ? 32'hEDB8_8320 : 32'h0000_8408;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ frm[i][k];
        c  = c >> 1;
        if (fb) c = c ^ p;
      end
    return c32 ? ~c : {16'h0, ~c[15:0]};
  endfunction

  task automatic send_frame(input int n, input bit c32, input bit corrupt, input bit good);
    logic [31:0] f;
    f = fcs_of(n, c32);
    if (corrupt) f = f ^ 32'h1;
    for (int i = 0; i < n; i++) data_byte(frm[i]);
    for (int i = 0; i < (c32 ? 4 : 2); i++) data_byte(f[8*i +: 8]);
    m_good = good;
  endtask

  task automatic compare(input string tag);
    repeat (4) @(negedge clk);
    chk(cap_n - cap_off == exp_n, {tag, " strobe count"}, cap_n - cap_off, exp_n);
    for (int i = cmp_base; i < exp_n && i + cap_off < cap_n; i++) begin
      chk(cap_d[i + cap_off] == exp_d[i], {tag, " data"}, cap_d[i + cap_off], exp_d[i]);
      chk({cap_i[i + cap_off], cap_v[i + cap_off]} == {exp_i[i], exp_v[i]},
          {tag, " idle/valfcs"}, {cap_i[i + cap_off], cap_v[i + cap_off]}, {exp_i[i], exp_v[i]});
    end
    cmp_base = exp_n;
    cap_off  = cap_n - exp_n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ia;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(strobe == 0, "R13 strobe", strobe, 0);
    chk(data == 0, "R13 data", data, 0);
    chk({idle, valfcs} == 2'b10, "R13 idle/valfcs", {idle, valfcs}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: full frame while disabled
    m_on = 0;
    frm[0] = 8'h11; frm[1] = 8'h22; frm[2] = 8'h33;
    send_flag(); send_frame(3, 0, 0, 1); send_flag();
    repeat (3) @(negedge clk);
    chk(cap_n == 0, "R1 strobes while disabled", cap_n, 0);
    chk({idle, valfcs} == 2'b10, "R1 status while disabled", {idle, valfcs}, 2'b10);

    // R2 R3 R4 R8 R10: CRC-16 frames, one flag between them
    en = 1'b1; m_on = 1;
    repeat (2) @(negedge clk);
    send_flag(); send_flag();
    frm[0] = 8'h01; frm[1] = 8'h80; frm[2] = 8'h7E; frm[3] = 8'hFF;
    frm[4] = 8'h3F; frm[5] = 8'h1F; frm[6] = 8'hF8;
    send_frame(7, 0, 0, 1); send_flag();
    ia = exp_n - 1;
    frm[0] = 8'hA5; frm[1] = 8'h5A; frm[2] = 8'hC3; frm[3] = 8'h00;
    send_frame(4, 0, 0, 1); send_flag(); send_flag();
    compare("R2 R3 R4 R10");
    chk(cap_d[ia] == 8'h7E && cap_i[ia] && !cap_i[ia - 1] && !cap_i[ia + 1],
        "R8 single flag between packets", {cap_i[ia - 1], cap_i[ia], cap_i[ia + 1]}, 3'b010);

    // R5: corrupted CRC-16
    send_frame(4, 0, 1, 0); send_flag();
    compare("R5 bad fcs16");

    // R9: all 256 octet values, both CRCs, plus wrong selection
    for (int i = 0; i < 256; i++) frm[i] = 8'(i);
    send_frame(256, 0, 0, 1); send_flag();
    compare("R9 crc16 sweep");
    sel32 = 1'b1;
    send_frame(256, 1, 0, 1); send_flag();
    send_frame(256, 1, 1, 0); send_flag();
    compare("R9 crc32 sweep");
    sel32 = 1'b0;
    frm[0] = 8'h12; frm[1] = 8'h34; frm[2] = 8'h56;
    send_frame(3, 1, 0, 0); send_flag();
    compare("R9 crc32 frame checked as crc16");

    // R6: abort after two octets, third still held
    frm[0] = 8'h0F; frm[1] = 8'h96;
    data_byte(8'h0F); data_byte(8'h96);
    m_on = 0; data_byte(8'h35); m_on = 1;
    for (int k = 0; k < 8; k++) raw_bit(1'b1);
    tx_ones = 0;
    m_idle = 0; m_val = 1; m_inmsg = 0;
    repeat (2) @(negedge clk);
    chk({idle, valfcs} == 2'b01, "R6 abort code", {idle, valfcs}, 2'b01);
    compare("R6 octets before abort");

    // R7: next message after abort
    send_flag();
    frm[0] = 8'hC0; frm[1] = 8'h03;
    send_frame(2, 0, 0, 1);
    repeat (2) @(negedge clk);
    chk({idle, valfcs} == 2'b00, "R7 status low in message", {idle, valfcs}, 2'b00);
    send_flag();
    compare("R7 after abort");

    // R12: three stray bits before the closing flag
    frm[0] = 8'h44; frm[1] = 8'h55; frm[2] = 8'h66;
    send_frame(3, 0, 0, 0);
    data_bit(1'b0); data_bit(1'b1); data_bit(1'b0);
    send_flag();
    compare("R12 non-aligned");

    // R11
    chk(stable_viol == 0, "R11 data stable between strobes", stable_viol, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule